// File: doc/BRIEF.md
# Conditional Move-Target Branch Unit

This block holds the control-flow state of a processor whose only instruction is a move from a source location to a destination location. It owns the program counter, an eight-entry hardware return stack, and two target holders, one for the zero case and one for the nonzero case. Either target holder, when read, yields the zero-case value if the zero flag is set and the nonzero-case value otherwise. Moving that selected value onto the program-counter location, the relative location or the call location gives a conditional jump, a conditional relative jump or a conditional call in a single move.

The surrounding move fabric presents one instruction per cycle on `step`. A destination write arrives on `wr_en`/`wr_loc`/`wr_data`. A source read addresses the block through `rd_loc`, and the value appears combinationally on `rd_data` so that the fabric can route it to a destination in the same cycle. A call saves the address of the next sequential instruction. Reading the return location pops that address back into the program counter. Instruction fetch and arithmetic live outside the block.

Top module: `move_branch_unit`

## Requirements
- R1: After a synchronous active-low reset, `pc` is 0 and `stack_ovf` is 0. Both target holders read 0, and the return stack is empty, so reading the return location yields 0.
- R2: The location codes are: 0 program counter, 1 relative, 2 call, 3 zero target, 4 nonzero target, 5 return. Codes 6 and 7 are unused. A write with code 3 loads only the zero target, and a write with code 4 loads only the nonzero target. Reading code 3 or code 4 returns the zero target when `zero_flag` is 1 and the nonzero target when `zero_flag` is 0.
- R3: A stepped write to code 0 makes `pc` equal to `wr_data` in the next cycle.
- R4: A stepped write to code 1 makes `pc` equal to old `pc` + 1 + `wr_data`. The offset is taken as two's complement, and the sum wraps modulo 2^16.
- R5: A stepped write to code 2 pushes old `pc` + 1 onto the return stack and loads `pc` with `wr_data`.
- R6: A stepped read of code 5 with a non-empty stack does three things: it presents the top entry on `rd_data`, it loads `pc` with that entry, and it removes the entry. Entries come back last-in first-out.
- R7: The stack holds 8 entries. A push onto a full stack sets `stack_ovf`, which stays 1 until reset. The same push discards the oldest entry, so the next 8 pops return the 8 newest pushes.
- R8: A stepped read of code 5 on an empty stack yields `rd_data` of 0, leaves the stack empty and advances `pc` by 1.
- R9: When `step` is 0, `pc`, the stack and both target holders keep their values, whatever the write and read inputs are.
- R10: A stepped cycle with no write to codes 0, 1 or 2 and no effective pop advances `pc` by 1.
- R11: When a stepped write to code 0, 1 or 2 coincides with an effective pop, the write decides the new `pc` and the pop still removes its entry. If the write is to code 2, the popped entry is replaced by the new return address, so the stack depth stays the same.
- R12: Reading code 0 returns the current `pc`. Reading code 1, 2, 6 or 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | One move instruction completes this cycle |
| zero_flag | input | 1 | Zero condition from the arithmetic side |
| wr_en | input | 1 | Move destination is one of this block's locations |
| wr_loc | input | 3 | Destination location code |
| wr_data | input | 16 | Value moved to the destination |
| rd_en | input | 1 | Move source is one of this block's locations (needed for a pop) |
| rd_loc | input | 3 | Source location code |
| rd_data | output | 16 | Combinational value of the source location |
| pc | output | 16 | Program counter |
| stack_ovf | output | 1 | Sticky return-stack overflow |

## Verification
The hardest state to reach is a full stack that has already wrapped. In that state the write position has lapped the oldest entry, and a pop must still return entries newest first and stop after exactly eight. The bench gets there by chaining ten calls. It then drains the stack with single-cycle return moves and compares each popped address against its own arithmetic record of the return addresses. The bench also sweeps every pairing of target values and zero-flag state, and a range of relative offsets that includes the wrap-around at the top of the address space.

// File: rtl/bu_pkg.sv
// Package: location codes and widths shared by the branch unit.
// Assumes every instance uses these codes on its read and write ports.
package bu_pkg;
    localparam int LOC_W = 3;
    typedef enum logic [LOC_W-1:0] {
        LOC_PC  = 3'd0,
        LOC_REL = 3'd1,
        LOC_IND = 3'd2,
        LOC_ZT  = 3'd3,
        LOC_NZT = 3'd4,
        LOC_RET = 3'd5
    } loc_e;
endpackage

// File: rtl/bu_target_sel.sv
// Module: two target holders with a read-side choice made by the zero flag.
// Assumes the loads are already qualified with the instruction step.
module bu_target_sel #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_z,
    input  logic          ld_nz,
    input  logic [AW-1:0] din,
    input  logic          zero_flag,
    output logic [AW-1:0] sel_out
);
    logic [AW-1:0] z_q, nz_q;

    // Hold the taken and not-taken targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q  <= '0;
            nz_q <= '0;
        end else begin
            if (ld_z)  z_q  <= din;
            if (ld_nz) nz_q <= din;
        end
    end

    // Pick a target from the current zero flag.
    always_comb sel_out = zero_flag ? z_q : nz_q;

    AST_NZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_nz && !zero_flag && $past(rst_n) && !$past(ld_nz) && !$past(zero_flag))
        |-> sel_out == $past(sel_out)); // R2
endmodule

// File: rtl/bu_ret_stack.sv
// Module: circular return-address stack.
// A push onto a full stack overwrites the oldest entry and sets a sticky flag.
// Assumes pop is only asserted together with a step.
module bu_ret_stack #(
    parameter int AW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] top,
    output logic          empty,
    output logic          ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [AW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] head_q, head_inc, head_dec;
    logic [CNT_W-1:0] cnt_q;
    logic             pop_eff;

    // Compute the neighbouring slot indices with wrap.
    always_comb begin
        head_inc = (head_q == LAST) ? '0 : head_q + 1'b1;
        head_dec = (head_q == '0) ? LAST : head_q - 1'b1;
        empty    = (cnt_q == '0);
        pop_eff  = pop && !empty;
        top      = mem[head_dec];
    end

    // Update the pointer, the count and the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
            ovf    <= 1'b0;
        end else if (push && pop_eff) begin
            head_q <= head_q;
        end else if (push) begin
            head_q <= head_inc;
            if (cnt_q == FULL) ovf <= 1'b1;
            else               cnt_q <= cnt_q + 1'b1;
        end else if (pop_eff) begin
            head_q <= head_dec;
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Write the storage slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push && pop_eff) begin
            mem[head_dec] <= din;
        end else if (push) begin
            mem[head_q] <= din;
        end
    end

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (top == $past(din)) && !empty); // R5
    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R7
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> empty); // R8
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL); // R7
endmodule

// File: rtl/bu_pc_next.sv
// Module: next program counter from the control writes and the return pop.
// Assumes at most one of the three control writes is active in a cycle.
module bu_pc_next #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] pc,
    input  logic          wr_pc,
    input  logic          wr_rel,
    input  logic          wr_ind,
    input  logic [AW-1:0] data,
    input  logic          pop_eff,
    input  logic [AW-1:0] top,
    output logic [AW-1:0] seq_pc,
    output logic [AW-1:0] next_pc
);
    // Priority: control write, then return pop, then sequential.
    always_comb begin
        seq_pc = pc + 1'b1;
        if (wr_pc || wr_ind) next_pc = data;
        else if (wr_rel)     next_pc = seq_pc + data;
        else if (pop_eff)    next_pc = top;
        else                 next_pc = seq_pc;
    end
endmodule

// File: rtl/move_branch_unit.sv
// Module: control-flow locations of a move-only processor. It holds the
// program counter, the relative and call locations, the zero and nonzero
// targets, and a return stack.
// Assumes one move per stepped cycle; rd_data is combinational so the fabric
// can route it to a destination within the same cycle.
module move_branch_unit #(
    parameter int AW       = 16,
    parameter int DEPTH    = 8,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          zero_flag,
    input  logic          wr_en,
    input  logic [2:0]    wr_loc,
    input  logic [AW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [2:0]    rd_loc,
    output logic [AW-1:0] rd_data,
    output logic [AW-1:0] pc,
    output logic          stack_ovf
);
    import bu_pkg::*;

    logic          wr_act, ld_z, ld_nz, wr_pc, wr_rel, wr_ind, pop, pop_eff;
    logic          stk_empty;
    logic [AW-1:0] sel_val, stk_top, seq_pc, next_pc;

    // Decode the destination and source of the current move.
    always_comb begin
        wr_act  = step && wr_en;
        ld_z    = wr_act && (wr_loc == LOC_ZT);
        ld_nz   = wr_act && (wr_loc == LOC_NZT);
        wr_pc   = wr_act && (wr_loc == LOC_PC);
        wr_rel  = wr_act && (wr_loc == LOC_REL);
        wr_ind  = wr_act && (wr_loc == LOC_IND);
        pop     = step && rd_en && (rd_loc == LOC_RET);
        pop_eff = pop && !stk_empty;
    end

    bu_target_sel #(.AW(AW)) u_sel (
        .clk(clk), .rst_n(rst_n), .ld_z(ld_z), .ld_nz(ld_nz),
        .din(wr_data), .zero_flag(zero_flag), .sel_out(sel_val)
    );

    bu_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(wr_ind), .pop(pop), .din(seq_pc),
        .top(stk_top), .empty(stk_empty), .ovf(stack_ovf)
    );

    bu_pc_next #(.AW(AW)) u_nxt (
        .pc(pc), .wr_pc(wr_pc), .wr_rel(wr_rel), .wr_ind(wr_ind),
        .data(wr_data), .pop_eff(pop_eff), .top(stk_top),
        .seq_pc(seq_pc), .next_pc(next_pc)
    );

    // Advance the program counter once per step.
    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= RESET_PC;
        else if (step) pc <= next_pc;
    end

    // Present the value of the addressed source location.
    always_comb begin
        unique case (rd_loc)
            LOC_PC:          rd_data = pc;
            LOC_ZT, LOC_NZT: rd_data = sel_val;
            LOC_RET:         rd_data = stk_empty ? '0 : stk_top;
            default:         rd_data = '0;
        endcase
    end

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wr_en && wr_loc == 3'd0) |=> pc == $past(wr_data)); // R3
    AST_REL_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wr_en && wr_loc == 3'd1) |=> pc == AW'($past(pc) + 1 + $past(wr_data))); // R4
    AST_SEQ_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !(wr_en && wr_loc <= 3'd2) && !(rd_en && rd_loc == 3'd5))
        |=> pc == AW'($past(pc) + 1)); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pc)); // R9
    AST_Z_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step && wr_en && wr_loc == 3'd3) && zero_flag && rd_loc == 3'd3)
        |-> rd_data == $past(wr_data)); // R2
endmodule

// File: tb/move_branch_unit_test.sv
module move_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0, zero_flag = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  wr_loc = '0, rd_loc = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data, pc;
    logic        stack_ovf;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // Bench record of the expected state.
    logic [15:0] e_pc, e_z, e_nz;
    logic [15:0] sm [8];
    int          scnt;
    logic        e_ovf;

    move_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .step(step), .zero_flag(zero_flag),
        .wr_en(wr_en), .wr_loc(wr_loc), .wr_data(wr_data), .rd_en(rd_en),
        .rd_loc(rd_loc), .rd_data(rd_data), .pc(pc), .stack_ovf(stack_ovf)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [2:0] rl);
        case (rl)
            3'd0:       return e_pc;
            3'd3, 3'd4: return zero_flag ? e_z : e_nz;
            3'd5:       return (scnt > 0) ? sm[scnt-1] : 16'h0;
            default:    return 16'h0;
        endcase
    endfunction

    // One stepped move; checks the source value, then pc and overflow.
    task automatic mv(input string tag, input logic we, input logic [2:0] wl,
                      input logic [15:0] wd, input logic re, input logic [2:0] rl);
        logic        pop_e, push_e;
        logic [15:0] npc, seq;
        @(negedge clk);
        step = 1'b1; wr_en = we; wr_loc = wl; wr_data = wd; rd_en = re; rd_loc = rl;
        #1 chk(tag, rd_data, exp_rd(rl));
        seq    = e_pc + 16'd1;
        pop_e  = re && rl == 3'd5 && scnt > 0;
        push_e = we && wl == 3'd2;
        npc    = seq;
        if (pop_e) npc = sm[scnt-1];
        if (we && (wl == 3'd0 || wl == 3'd2)) npc = wd;
        if (we && wl == 3'd1) npc = seq + wd;
        if (we && wl == 3'd3) e_z = wd;
        if (we && wl == 3'd4) e_nz = wd;
        if (push_e && pop_e) sm[scnt-1] = seq;
        else if (push_e) begin
            if (scnt == 8) begin
                for (int i = 0; i < 7; i++) sm[i] = sm[i+1];
                sm[7] = seq; e_ovf = 1'b1;
            end else begin
                sm[scnt] = seq; scnt++;
            end
        end else if (pop_e) scnt--;
        e_pc = npc;
        @(posedge clk); #1;
        step = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        chk(tag, pc, e_pc);
        chk(tag, {15'd0, stack_ovf}, {15'd0, e_ovf});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] offs [6];
        e_pc = 0; e_z = 0; e_nz = 0; scnt = 0; e_ovf = 0;
        for (int i = 0; i < 8; i++) sm[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        #1 chk("R1 pc", pc, 16'h0);
        chk("R1 ovf", {15'd0, stack_ovf}, 16'h0);
        rd_loc = 3'd3; #1 chk("R1 ztarget", rd_data, 16'h0);
        rd_loc = 3'd5; #1 chk("R1 ret empty", rd_data, 16'h0);

        // R10: sequential advance
        for (int i = 0; i < 5; i++) mv("R10 seq", 1'b0, 3'd0, 16'h0, 1'b0, 3'd0);

        // R2: sweep target pairs and both flag states
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                mv("R2 ldz", 1'b1, 3'd3, 16'(16'h1000 * a + 3), 1'b0, 3'd0);
                mv("R2 ldnz", 1'b1, 3'd4, 16'(16'h0100 * b + 7), 1'b0, 3'd0);
                for (int f = 0; f < 2; f++) begin
                    zero_flag = f[0];
                    mv("R2 readz", 1'b0, 3'd0, 16'h0, 1'b1, 3'd3);
                    mv("R2 readnz", 1'b0, 3'd0, 16'h0, 1'b1, 3'd4);
                end
            end

        // R9: no step means no effect
        @(negedge clk);
        wr_en = 1'b1; wr_loc = 3'd0; wr_data = 16'hBEEF;
        @(negedge clk);
        wr_loc = 3'd3; wr_data = 16'hDEAD; zero_flag = 1'b1;
        @(negedge clk);
        wr_loc = 3'd2; rd_en = 1'b1; rd_loc = 3'd3;
        #1 chk("R9 pc held", pc, e_pc);
        chk("R9 ztarget held", rd_data, e_z);
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        rd_loc = 3'd5; #1 chk("R9 stack untouched", rd_data, 16'h0);

        // R3: jump sweep
        for (int t = 0; t < 8; t++) mv("R3 jump", 1'b1, 3'd0, 16'(t * 16'h2345), 1'b0, 3'd0);

        // R4: relative sweep, including wrap
        offs[0] = 16'h8000; offs[1] = 16'h7FFF; offs[2] = 16'hFFFF;
        offs[3] = 16'h0010; offs[4] = 16'hFFF0; offs[5] = 16'h0000;
        mv("R4 base", 1'b1, 3'd0, 16'hFFF8, 1'b0, 3'd0);
        for (int o = -8; o < 8; o++) mv("R4 rel", 1'b1, 3'd1, 16'(o), 1'b0, 3'd0);
        for (int k = 0; k < 6; k++) mv("R4 rel wide", 1'b1, 3'd1, offs[k], 1'b0, 3'd0);

        // R5 R6: nested calls of depth 1..8, then unwind
        for (int d = 1; d <= 8; d++) begin
            mv("R5 base", 1'b1, 3'd0, 16'(16'h0400 * d), 1'b0, 3'd0);
            for (int c = 0; c < d; c++) mv("R5 call", 1'b1, 3'd2, 16'(16'h3000 + 16 * c), 1'b0, 3'd0);
            for (int c = 0; c < d; c++) mv("R6 return", 1'b0, 3'd0, 16'h0, 1'b1, 3'd5);
        end

        // R5 with conditional call through the targets
        mv("R5 ldz", 1'b1, 3'd3, 16'h5000, 1'b0, 3'd0);
        mv("R5 ldnz", 1'b1, 3'd4, 16'h6000, 1'b0, 3'd0);
        zero_flag = 1'b0;
        mv("R5 cond call nz", 1'b1, 3'd2, e_nz, 1'b1, 3'd4);
        mv("R6 cond return", 1'b0, 3'd0, 16'h0, 1'b1, 3'd5);

        // R8: pop on empty
        mv("R8 pop empty", 1'b0, 3'd0, 16'h0, 1'b1, 3'd5);
        mv("R8 pop empty again", 1'b0, 3'd0, 16'h0, 1'b1, 3'd5);

        // R11: return-to-call tail move and return with jump
        mv("R11 call", 1'b1, 3'd2, 16'h7000, 1'b0, 3'd0);
        mv("R11 call2", 1'b1, 3'd2, 16'h7100, 1'b0, 3'd0);
        mv("R11 tail", 1'b1, 3'd2, exp_rd(3'd5), 1'b1, 3'd5);
        mv("R11 ret jump", 1'b1, 3'd0, 16'h0123, 1'b1, 3'd5);
        mv("R11 ret last", 1'b0, 3'd0, 16'h0, 1'b1, 3'd5);
        mv("R11 empty", 1'b0, 3'd0, 16'h0, 1'b1, 3'd5);

        // R12: plain reads of each code
        for (int l = 0; l < 8; l++) mv("R12 read", 1'b0, 3'd0, 16'h0, 1'b0, 3'(l));

        // R7: overflow after ten pushes, then drain
        mv("R7 base", 1'b1, 3'd0, 16'h0800, 1'b0, 3'd0);
        for (int c = 0; c < 10; c++) mv("R7 push", 1'b1, 3'd2, 16'(16'h0900 + 32 * c), 1'b0, 3'd0);
        for (int c = 0; c < 9; c++) mv("R7 drain", 1'b0, 3'd0, 16'h0, 1'b1, 3'd5);
        mv("R7 sticky", 1'b0, 3'd0, 16'h0, 1'b0, 3'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule